// File: doc/BRIEF.md
# Operand Effective Address Generator

This block turns an addressing-mode code and the operand fields of a complex instruction into the memory address of that operand. The decoder supplies the fields. The register file supplies up to two read values. The block returns the effective address, a flag that says no memory access is needed, and an optional base-register write-back for the post-increment and pre-decrement modes.

For the pointer-through-memory mode, the block issues a single pointer read, waits for the returned word, and uses that word as the address. Every other mode finishes in the cycle after `start`.

The results are registered. They are valid while `done` is high and stay unchanged until the next operation completes. A `start` is accepted only while `busy` is low.

Top module: `opnd_addr_unit`

## Requirements
- R1: While reset is active and in the first cycle after it, `done`, `busy`, `ptr_req`, `no_mem` and `wb_en` are low and `ea` is zero.
- R2: A `start` accepted with any mode other than 9 raises `done` for exactly the following cycle. `ea` keeps its value in the cycles after that until the next completion.
- R3: The address is computed by mode code, with all arithmetic wrapping modulo 2^AW:
  - Mode 2 (absolute): the zero-extended `fld`.
  - Mode 3 (register pointer): `ra_val`.
  - Mode 4 (base plus offset): `ra_val` plus the sign-extended `fld`.
  - Mode 5 (two-register sum): `ra_val + rb_val`.
- R4: Mode 6 (scaled index) gives sign-extended `fld` + `ra_val` + `rb_val` × 2^`size`, where `size` codes 0..3 mean 1, 2, 4 and 8 bytes.
- R5: Mode 7 (post-increment) gives `ea = ra_val`. In the same `done` cycle it sets `wb_en=1`, `wb_idx = ra_idx` and `wb_val = ra_val + 2^size`.
- R6: Mode 8 (pre-decrement) gives `wb_val = ra_val - 2^size` with `wb_en=1` and `wb_idx = ra_idx`. It also gives `ea = wb_val`.
- R7: Mode 9 (pointer through memory) behaves as follows:
  - In the cycle after `start`, `ptr_req` is high for one cycle with `ptr_addr = ra_val`.
  - `busy` stays high until a cycle with `ptr_valid` high.
  - In the cycle after that, `done` is high and `ea = ptr_data`.
- R8: Mode 0 (register operand) and mode 1 (immediate operand) complete with `no_mem=1`, `wb_en=0` and `ea` zero.
- R9: While `busy` is high, `start` has no effect. While `busy` is low, `ptr_valid` has no effect.
- R10: Mode codes 10 to 15 complete like mode 0: `no_mem=1`, `wb_en=0` and `ea` zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| start | input | 1 | begin an address computation |
| mode | input | 4 | addressing-mode code |
| size | input | 2 | operand size code (bytes = 2^size) |
| ra_val | input | AW | base register value |
| rb_val | input | AW | index register value |
| ra_idx | input | RW | index of the base register |
| fld | input | FW | offset or absolute address field |
| ptr_valid | input | 1 | pointer read data valid |
| ptr_data | input | AW | pointer read data |
| busy | output | 1 | waiting for pointer data |
| done | output | 1 | result valid this cycle |
| ea | output | AW | effective address |
| no_mem | output | 1 | operand needs no memory access |
| wb_en | output | 1 | base register write-back enable |
| wb_idx | output | RW | write-back register index |
| wb_val | output | AW | write-back value |
| ptr_req | output | 1 | pointer read request |
| ptr_addr | output | AW | pointer read address |

## Verification
The hardest case to reach is the pointer-wait state while other traffic arrives. It needs a `start` that must be ignored, combined with a late or immediate `ptr_valid`, and then a stray `ptr_valid` once the block is idle again.

The stimulus covers this in two ways:
- Directed sequences drive a rejected `start` and a stray `ptr_valid` explicitly.
- Random pointer latencies from one to four cycles are mixed with random `start` pulses during the wait and random `ptr_valid` pulses while idle.

Offsets of both signs and register values near the top of the address space exercise the wrap-around.

// File: rtl/opnd_addr_pkg.sv
package opnd_addr_pkg;
  localparam logic [3:0] AM_REG    = 4'd0;
  localparam logic [3:0] AM_IMM    = 4'd1;
  localparam logic [3:0] AM_ABS    = 4'd2;
  localparam logic [3:0] AM_RPTR   = 4'd3;
  localparam logic [3:0] AM_BOFS   = 4'd4;
  localparam logic [3:0] AM_SUM    = 4'd5;
  localparam logic [3:0] AM_SCALED = 4'd6;
  localparam logic [3:0] AM_POSTINC = 4'd7;
  localparam logic [3:0] AM_PREDEC = 4'd8;
  localparam logic [3:0] AM_MEMPTR = 4'd9;

  typedef enum logic {ST_IDLE = 1'b0, ST_FETCH = 1'b1} fsm_e;
endpackage

// File: rtl/opnd_addr_calc.sv
module opnd_addr_calc
  import opnd_addr_pkg::*;
#(
  parameter int AW = 32,
  parameter int FW = 16
) (
  input  logic [3:0]    mode,
  input  logic [1:0]    size,
  input  logic [AW-1:0] ra_val,
  input  logic [AW-1:0] rb_val,
  input  logic [FW-1:0] fld,
  output logic [AW-1:0] ea_c,
  output logic [AW-1:0] wb_val_c,
  output logic          wb_en_c,
  output logic          no_mem_c,
  output logic          is_ind
);
  localparam int XW = AW - FW;

  function automatic logic [AW-1:0] sext_fld(input logic [FW-1:0] f);
    return {{XW{f[FW-1]}}, f};
  endfunction

  function automatic logic [AW-1:0] zext_fld(input logic [FW-1:0] f);
    return {{XW{1'b0}}, f};
  endfunction

  function automatic logic [AW-1:0] step_of(input logic [1:0] s);
    return {{(AW-1){1'b0}}, 1'b1} << s;
  endfunction

  function automatic logic [AW-1:0] scaled_idx(input logic [AW-1:0] v, input logic [1:0] s);
    return v << s;
  endfunction

  always_comb begin
    ea_c     = '0;
    wb_val_c = '0;
    wb_en_c  = 1'b0;
    no_mem_c = 1'b0;
    is_ind   = 1'b0;
    case (mode)
      AM_ABS:     ea_c = zext_fld(fld);
      AM_RPTR:    ea_c = ra_val;
      AM_BOFS:    ea_c = ra_val + sext_fld(fld);
      AM_SUM:     ea_c = ra_val + rb_val;
      AM_SCALED:  ea_c = sext_fld(fld) + ra_val + scaled_idx(rb_val, size);
      AM_POSTINC: begin
        ea_c     = ra_val;
        wb_val_c = ra_val + step_of(size);
        wb_en_c  = 1'b1;
      end
      AM_PREDEC: begin
        wb_val_c = ra_val - step_of(size);
        ea_c     = wb_val_c;
        wb_en_c  = 1'b1;
      end
      AM_MEMPTR:  is_ind = 1'b1;
      default:    no_mem_c = 1'b1;
    endcase
  end
endmodule

// File: rtl/opnd_addr_ctrl.sv
module opnd_addr_ctrl
  import opnd_addr_pkg::*;
#(
  parameter int AW = 32,
  parameter int RW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          is_ind,
  input  logic [AW-1:0] ea_c,
  input  logic [AW-1:0] wb_val_c,
  input  logic          wb_en_c,
  input  logic          no_mem_c,
  input  logic [AW-1:0] ra_val,
  input  logic [RW-1:0] ra_idx,
  input  logic          ptr_valid,
  input  logic [AW-1:0] ptr_data,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] ea,
  output logic          no_mem,
  output logic          wb_en,
  output logic [RW-1:0] wb_idx,
  output logic [AW-1:0] wb_val,
  output logic          ptr_req,
  output logic [AW-1:0] ptr_addr
);
  fsm_e state;

  logic accept_fast;
  logic accept_ind;
  logic ptr_return;

  assign accept_fast = start && (state == ST_IDLE) && !is_ind;
  assign accept_ind  = start && (state == ST_IDLE) && is_ind;
  assign ptr_return  = (state == ST_FETCH) && ptr_valid;
  assign busy        = (state == ST_FETCH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      done     <= 1'b0;
      ea       <= '0;
      no_mem   <= 1'b0;
      wb_en    <= 1'b0;
      wb_idx   <= '0;
      wb_val   <= '0;
      ptr_req  <= 1'b0;
      ptr_addr <= '0;
    end else begin
      done    <= accept_fast || ptr_return;
      no_mem  <= accept_fast && no_mem_c;
      wb_en   <= accept_fast && wb_en_c;
      ptr_req <= accept_ind;
      if (accept_ind) begin
        state    <= ST_FETCH;
        ptr_addr <= ra_val;
      end
      if (accept_fast) begin
        ea     <= ea_c;
        wb_val <= wb_val_c;
        wb_idx <= ra_idx;
      end
      if (ptr_return) begin
        state  <= ST_IDLE;
        ea     <= ptr_data;
        wb_val <= '0;
      end
    end
  end

  a_r2_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
    accept_fast |=> done);
  a_r7_req_single: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_req |=> !ptr_req);
  a_r7_ptr_result: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_return |=> (done && ea == $past(ptr_data)));
  a_r8_nomem_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
    no_mem |-> !wb_en);
  a_r5_wb_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> done);
  a_r9_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ptr_valid) |=> (busy && !done));
  a_r7_req_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_req |-> busy);
endmodule

// File: rtl/opnd_addr_unit.sv
module opnd_addr_unit
  import opnd_addr_pkg::*;
#(
  parameter int AW = 32,
  parameter int FW = 16,
  parameter int RW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [3:0]    mode,
  input  logic [1:0]    size,
  input  logic [AW-1:0] ra_val,
  input  logic [AW-1:0] rb_val,
  input  logic [RW-1:0] ra_idx,
  input  logic [FW-1:0] fld,
  input  logic          ptr_valid,
  input  logic [AW-1:0] ptr_data,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] ea,
  output logic          no_mem,
  output logic          wb_en,
  output logic [RW-1:0] wb_idx,
  output logic [AW-1:0] wb_val,
  output logic          ptr_req,
  output logic [AW-1:0] ptr_addr
);
  logic [AW-1:0] ea_c;
  logic [AW-1:0] wb_val_c;
  logic          wb_en_c;
  logic          no_mem_c;
  logic          is_ind;

  opnd_addr_calc #(.AW(AW), .FW(FW)) u_calc (
    .mode(mode), .size(size), .ra_val(ra_val), .rb_val(rb_val), .fld(fld),
    .ea_c(ea_c), .wb_val_c(wb_val_c), .wb_en_c(wb_en_c),
    .no_mem_c(no_mem_c), .is_ind(is_ind)
  );

  opnd_addr_ctrl #(.AW(AW), .RW(RW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .is_ind(is_ind),
    .ea_c(ea_c), .wb_val_c(wb_val_c), .wb_en_c(wb_en_c), .no_mem_c(no_mem_c),
    .ra_val(ra_val), .ra_idx(ra_idx), .ptr_valid(ptr_valid), .ptr_data(ptr_data),
    .busy(busy), .done(done), .ea(ea), .no_mem(no_mem), .wb_en(wb_en),
    .wb_idx(wb_idx), .wb_val(wb_val), .ptr_req(ptr_req), .ptr_addr(ptr_addr)
  );
endmodule

// File: tb/test_opnd_addr_unit.sv
module test_opnd_addr_unit;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [3:0] mode = '0;
  logic [1:0] size = '0;
  logic [31:0] ra_val = '0, rb_val = '0, ptr_data = '0;
  logic [3:0] ra_idx = '0;
  logic [15:0] fld = '0;
  logic ptr_valid = 1'b0;
  logic busy, done, no_mem, wb_en, ptr_req;
  logic [31:0] ea, wb_val, ptr_addr;
  logic [3:0] wb_idx;

  always #(CLK_PERIOD/2) clk = ~clk;

  opnd_addr_unit i_opnd_addr_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .size(size),
    .ra_val(ra_val), .rb_val(rb_val), .ra_idx(ra_idx), .fld(fld),
    .ptr_valid(ptr_valid), .ptr_data(ptr_data), .busy(busy), .done(done),
    .ea(ea), .no_mem(no_mem), .wb_en(wb_en), .wb_idx(wb_idx), .wb_val(wb_val),
    .ptr_req(ptr_req), .ptr_addr(ptr_addr)
  );

  int vectors = 0;
  int misses = 0;
  string cur_req = "R1";
  bit finished = 0;

  // reference state
  bit m_busy, m_done, m_nomem, m_wben, m_req;
  logic [31:0] m_ea, m_wbv, m_paddr;
  logic [3:0] m_wbi;

  function automatic string tag_of(input logic [3:0] md);
    case (md)
      4'd0, 4'd1: return "R8";
      4'd2, 4'd3, 4'd4, 4'd5: return "R3";
      4'd6: return "R4";
      4'd7: return "R5";
      4'd8: return "R6";
      4'd9: return "R7";
      default: return "R10";
    endcase
  endfunction

  task automatic model_step();
    longint sx, a, b, r, w;
    longint unsigned stp;
    m_done = 0; m_nomem = 0; m_wben = 0; m_req = 0;
    if (m_busy) begin
      if (ptr_valid) begin
        m_busy = 0; m_done = 1; m_ea = ptr_data; m_wbv = 0;
      end
    end else if (start) begin
      if (mode == 4'd9) begin
        m_busy = 1; m_req = 1; m_paddr = ra_val;
      end else begin
        sx = (fld >= 16'h8000) ? longint'(fld) - 65536 : longint'(fld);
        a = longint'(ra_val); b = longint'(rb_val);
        stp = 64'd1 << size;
        r = 0; w = 0;
        case (mode)
          4'd2: r = longint'(fld);
          4'd3: r = a;
          4'd4: r = a + sx;
          4'd5: r = a + b;
          4'd6: r = sx + a + b * longint'(stp);
          4'd7: begin r = a; w = a + longint'(stp); m_wben = 1; end
          4'd8: begin w = a - longint'(stp); r = w; m_wben = 1; end
          default: m_nomem = 1;
        endcase
        m_ea = r[31:0]; m_wbv = w[31:0]; m_wbi = ra_idx; m_done = 1;
      end
    end
  endtask

  task automatic chk1(input string what, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      misses++;
      $display("FAIL %s %s: got %h expected %h", cur_req, what, got, exp);
    end
  endtask

  task automatic compare();
    chk1("done", 32'(done), 32'(m_done));
    chk1("busy", 32'(busy), 32'(m_busy));
    chk1("ptr_req", 32'(ptr_req), 32'(m_req));
    chk1("no_mem", 32'(no_mem), 32'(m_nomem));
    chk1("wb_en", 32'(wb_en), 32'(m_wben));
    chk1("ea", ea, m_ea);
    if (m_req) chk1("ptr_addr", ptr_addr, m_paddr);
    if (m_wben) begin
      chk1("wb_val", wb_val, m_wbv);
      chk1("wb_idx", 32'(wb_idx), 32'(m_wbi));
    end
  endtask

  task automatic cyc();
    model_step();
    @(negedge clk);
    compare();
  endtask

  task automatic set_fields(input logic [3:0] md, input logic [1:0] sz,
                            input logic [31:0] a, input logic [31:0] b,
                            input logic [3:0] ix, input logic [15:0] f);
    mode = md; size = sz; ra_val = a; rb_val = b; ra_idx = ix; fld = f;
  endtask

  // one operation; lat = cycles until ptr_valid for mode 9
  task automatic op(input logic [3:0] md, input logic [1:0] sz, input logic [31:0] a,
                    input logic [31:0] b, input logic [3:0] ix, input logic [15:0] f,
                    input int lat, input logic [31:0] pd, input bit noisy);
    cur_req = tag_of(md);
    set_fields(md, sz, a, b, ix, f);
    start = 1;
    cyc();
    start = 0;
    if (md == 4'd9) begin
      for (int k = 1; k < lat; k++) begin
        if (noisy) begin
          cur_req = "R9";
          start = 1'($urandom_range(0, 1));
          set_fields(4'($urandom_range(0, 8)), 2'($urandom), $urandom, $urandom, 4'($urandom), 16'($urandom));
        end
        ptr_valid = 0;
        cyc();
        start = 0;
      end
      cur_req = "R7";
      ptr_valid = 1; ptr_data = pd;
      cyc();
      ptr_valid = 0;
    end
    cur_req = "R2";
    if (noisy) begin
      cur_req = "R9";
      ptr_valid = 1; ptr_data = $urandom;
    end
    cyc();
    ptr_valid = 0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    misses++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    m_busy = 0; m_done = 0; m_nomem = 0; m_wben = 0; m_req = 0;
    m_ea = 0; m_wbv = 0; m_paddr = 0; m_wbi = 0;
    repeat (3) @(negedge clk);
    cur_req = "R1";
    compare();
    rst_n = 1;
    cyc();
    // R3 directed, incl. negative offset and wrap
    op(4'd2, 2'd0, 32'h0, 32'h0, 4'd1, 16'hF000, 0, 0, 0);
    op(4'd3, 2'd0, 32'h1234_5678, 32'h0, 4'd2, 16'h0, 0, 0, 0);
    op(4'd4, 2'd0, 32'h0000_0010, 32'h0, 4'd2, 16'hFFF0, 0, 0, 0);
    op(4'd4, 2'd0, 32'hFFFF_FFF0, 32'h0, 4'd2, 16'h0020, 0, 0, 0);
    op(4'd5, 2'd0, 32'hFFFF_FFFF, 32'h2, 4'd3, 16'h0, 0, 0, 0);
    // R4 every scale
    for (int s = 0; s < 4; s++)
      op(4'd6, 2'(s), 32'h1000, 32'h3, 4'd4, 16'hFFFC, 0, 0, 0);
    // R5 / R6 wrap at the ends
    op(4'd7, 2'd3, 32'hFFFF_FFFC, 32'h0, 4'd5, 16'h0, 0, 0, 0);
    op(4'd8, 2'd2, 32'h0000_0002, 32'h0, 4'd6, 16'h0, 0, 0, 0);
    op(4'd8, 2'd0, 32'h100, 32'h0, 4'd7, 16'h0, 0, 0, 0);
    // R8, R10
    op(4'd0, 2'd1, 32'h55, 32'h66, 4'd8, 16'h77, 0, 0, 0);
    op(4'd1, 2'd1, 32'h55, 32'h66, 4'd8, 16'h77, 0, 0, 0);
    op(4'd12, 2'd1, 32'h55, 32'h66, 4'd9, 16'h77, 0, 0, 0);
    // R7 immediate and late reply
    op(4'd9, 2'd0, 32'hABCD_0000, 32'h0, 4'd1, 16'h0, 1, 32'hDEAD_BEEF, 0);
    op(4'd9, 2'd0, 32'h0000_4444, 32'h0, 4'd1, 16'h0, 4, 32'h0BAD_F00D, 0);
    // R9 directed: start during wait, stray ptr_valid when idle
    op(4'd9, 2'd0, 32'h10, 32'h0, 4'd1, 16'h0, 3, 32'h2222_2222, 1);
    cur_req = "R9";
    ptr_valid = 1; ptr_data = 32'h9999_9999;
    cyc(); cyc();
    ptr_valid = 0;
    cyc();
    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [3:0] md;
      md = 4'($urandom_range(0, 15));
      if (n % 3 == 0) md = 4'd9;
      op(md, 2'($urandom), $urandom, $urandom, 4'($urandom), 16'($urandom),
         $urandom_range(1, 4), $urandom, bit'($urandom_range(0, 1)));
    end
    summary();
  end
endmodule